// File: doc/BRIEF.md
# Duty-Cycle Modulated Isolation Transmitter

This block sends one control bit across a pulse transformer. It drives two complementary outputs that sit on the two ends of the primary winding. The bit is carried by which output is pulled low during a short timed interval and which is pulled low during the longer interval after it. Because the receiver decodes the polarity duty cycle of every cycle, a steady level is carried as well as edges. The drive keeps cycling even while the control bit does not change.

Every cycle opens with a one-shot of programmable length. A rest interval follows it and ends when the zero-current strobe arrives. If the strobe never arrives, a timeout of eight one-shot lengths starts the next cycle. The control input is synchronized, and a change on it swaps the phase assignment at once, in the middle of the current interval. A low transmit-enable, which is driven by an external fault latch, stops the drive completely.

Each output is reported as a two-bit phase code because a digital pin cannot show the reduced analog level that one output takes during rest.

Top module: `dcm_tx`

## Requirements
- R1: During and right after reset, both phase outputs are 2'b00 (inactive) and `cyc_start` is 0.
- R2: When `tx_en` is 0 at a clock edge, both phase outputs are 2'b00 and `cyc_start` is 0 after that edge. When `tx_en` returns to 1, a new one-shot starts on the following edge.
- R3: A one-shot lasts exactly `shot_len` clock cycles. `cyc_start` is high for the first of those cycles only.
- R4: With the synchronized control bit at 1, `drv_a` is 2'b01 (low) and `drv_b` is 2'b10 (high) during the one-shot. During the rest interval, `drv_a` is 2'b10 (high) and `drv_b` is 2'b11 (weak, reduced level).
- R5: With the synchronized control bit at 0, the roles are exchanged. During the one-shot, `drv_a` is 2'b10 and `drv_b` is 2'b01. During the rest interval, `drv_a` is 2'b11 and `drv_b` is 2'b10.
- R6: `zc_in` high at an edge during the rest interval ends that interval, and the next cycle is a new one-shot with `cyc_start` high. `zc_in` during a one-shot has no effect.
- R7: Without `zc_in`, the rest interval ends after 8 × `shot_len` cycles, so the full period is 9 × `shot_len` cycles.
- R8: A change on `ctrl_in` shows at the outputs two clock edges after it is first sampled, inside the current interval. It does not alter the interval timing.
- R9: A `shot_len` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_in | input | 1 | Asynchronous control bit to transmit |
| zc_in | input | 1 | Zero-current strobe from the primary current comparator |
| tx_en | input | 1 | Transmit enable; low while a fault is latched |
| shot_len | input | LEN_W | One-shot length in clock cycles |
| drv_a | output | 2 | Phase code of output A (00 off, 01 low, 10 high, 11 weak) |
| drv_b | output | 2 | Phase code of output B, same encoding |
| cyc_start | output | 1 | One-cycle strobe at the start of each one-shot |

## Verification
The hardest situations to reach from the ports involve the control bit flipping partway through an interval. One case is the interval's last cycle, where the flip must swap the phases without moving the boundary. Another is a zero-current strobe that lands inside the one-shot, where it must be ignored. The random phase changes the control bit rarely and at arbitrary cycles, and it raises the strobe at arbitrary points in both intervals. Directed runs pin down the eight-length timeout, the zero length and a flip in mid-rest.

// File: rtl/dcm_tx_pkg.sv
package dcm_tx_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'b00,
        PH_LOW  = 2'b01,
        PH_HIGH = 2'b10,
        PH_WEAK = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_SHOT = 2'b01,
        SEQ_REST = 2'b10
    } seq_e;

    typedef struct packed {
        phase_e a;
        phase_e b;
    } drive_t;

    localparam int REST_MULT = 8;

    // phase pair for one interval and one control level
    function automatic drive_t phase_for(seq_e st, logic bit_v);
        drive_t d;
        d.a = PH_OFF;
        d.b = PH_OFF;
        case (st)
            SEQ_SHOT: begin
                d.a = bit_v ? PH_LOW  : PH_HIGH;
                d.b = bit_v ? PH_HIGH : PH_LOW;
            end
            SEQ_REST: begin
                d.a = bit_v ? PH_HIGH : PH_WEAK;
                d.b = bit_v ? PH_WEAK : PH_HIGH;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dcm_sync.sv
module dcm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/dcm_seq.sv
module dcm_seq
    import dcm_tx_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int MULT  = REST_MULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             zc_in,
    input  logic [LEN_W-1:0] shot_len,
    output seq_e             st,
    output logic             start
);
    localparam int CNT_W = LEN_W + $clog2(MULT) + 1;

    logic [CNT_W-1:0] cnt, cnt_n, shot_lim, rest_lim;
    seq_e             st_n;
    logic             start_n;

    always_comb begin
        shot_lim = (shot_len == '0) ? CNT_W'(1) : CNT_W'(shot_len);
        rest_lim = shot_lim * CNT_W'(MULT);
    end

    always_comb begin
        st_n    = st;
        cnt_n   = cnt + 1'b1;
        start_n = 1'b0;
        if (!tx_en) begin
            st_n  = SEQ_IDLE;
            cnt_n = '0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    st_n    = SEQ_SHOT;
                    cnt_n   = '0;
                    start_n = 1'b1;
                end
                SEQ_SHOT: begin
                    if (cnt >= shot_lim - 1'b1) begin
                        st_n  = SEQ_REST;
                        cnt_n = '0;
                    end
                end
                SEQ_REST: begin
                    if (zc_in || cnt >= rest_lim - 1'b1) begin
                        st_n    = SEQ_SHOT;
                        cnt_n   = '0;
                        start_n = 1'b1;
                    end
                end
                default: begin
                    st_n  = SEQ_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SEQ_IDLE;
            cnt   <= '0;
            start <= 1'b0;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            start <= start_n;
        end
    end
endmodule

// File: rtl/dcm_phase_map.sv
module dcm_phase_map
    import dcm_tx_pkg::*;
(
    input  seq_e   st,
    input  logic   ctrl_s,
    output drive_t drv
);
    always_comb drv = phase_for(st, ctrl_s);
endmodule

// File: rtl/dcm_tx.sv
module dcm_tx
    import dcm_tx_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_in,
    input  logic             zc_in,
    input  logic             tx_en,
    input  logic [LEN_W-1:0] shot_len,
    output logic [1:0]       drv_a,
    output logic [1:0]       drv_b,
    output logic             cyc_start
);
    logic   ctrl_s;
    seq_e   st;
    drive_t drv;

    dcm_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (ctrl_in),
        .d_out (ctrl_s)
    );

    dcm_seq #(.LEN_W(LEN_W), .MULT(REST_MULT)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .zc_in    (zc_in),
        .shot_len (shot_len),
        .st       (st),
        .start    (cyc_start)
    );

    dcm_phase_map u_map (
        .st     (st),
        .ctrl_s (ctrl_s),
        .drv    (drv)
    );

    assign drv_a = drv.a;
    assign drv_b = drv.b;
endmodule

// File: rtl/dcm_tx_chk.sv
module dcm_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       zc_in,
    input logic       tx_en,
    input logic [1:0] drv_a,
    input logic [1:0] drv_b,
    input logic       cyc_start
);
    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (drv_a == 2'b00 && drv_b == 2'b00 && !cyc_start));

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_start |=> !cyc_start);

    // R4
    start_in_shot_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_start |-> (drv_a == 2'b01 || drv_b == 2'b01));

    // R5
    paired_active_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_a == 2'b00) == (drv_b == 2'b00));

    // R6
    zc_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en && zc_in && (drv_a == 2'b11 || drv_b == 2'b11)) |=> cyc_start);
endmodule

bind dcm_tx dcm_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .zc_in     (zc_in),
    .tx_en     (tx_en),
    .drv_a     (drv_a),
    .drv_b     (drv_b),
    .cyc_start (cyc_start)
);

// File: tb/dcm_tx_bench.sv
`timescale 1ns/1ps
module dcm_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_in = 1'b0, zc_in = 1'b0, tx_en = 1'b0;
    logic [7:0] shot_len = 8'd3;
    logic [1:0] drv_a, drv_b;
    logic       cyc_start;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // reference state
    int m_st = 0, m_cnt = 0;
    bit m_s1 = 0, m_s2 = 0, m_start = 0;

    always #2 clk = ~clk;

    dcm_tx u_dcm_tx (
        .clk(clk), .rst(rst), .ctrl_in(ctrl_in), .zc_in(zc_in),
        .tx_en(tx_en), .shot_len(shot_len),
        .drv_a(drv_a), .drv_b(drv_b), .cyc_start(cyc_start)
    );

    function automatic logic [1:0] want_a(int st, bit b);
        if (st == 1) return b ? 2'b01 : 2'b10;
        if (st == 2) return b ? 2'b10 : 2'b11;
        return 2'b00;
    endfunction

    function automatic logic [1:0] want_b(int st, bit b);
        if (st == 1) return b ? 2'b10 : 2'b01;
        if (st == 2) return b ? 2'b11 : 2'b10;
        return 2'b00;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int ns, nc, le;
        bit nstart;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_start = 0;
            return;
        end
        le = (shot_len == 0) ? 1 : int'(shot_len);
        ns = m_st; nc = m_cnt + 1; nstart = 0;
        if (!tx_en) begin
            ns = 0; nc = 0;
        end else if (m_st == 0) begin
            ns = 1; nc = 0; nstart = 1;
        end else if (m_st == 1) begin
            if (m_cnt >= le - 1) begin ns = 2; nc = 0; end
        end else if (zc_in || m_cnt >= 8 * le - 1) begin
            ns = 1; nc = 0; nstart = 1;
        end
        m_st = ns; m_cnt = nc; m_start = nstart;
        m_s2 = m_s1; m_s1 = ctrl_in;
    endtask

    // called at a negedge: drive, clock, compare at next negedge
    task automatic step(bit en, bit zc, bit c, logic [7:0] len, string tag);
        tx_en = en; zc_in = zc; ctrl_in = c; shot_len = len;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "drv_a", drv_a, want_a(m_st, m_s2));
        check(tag, "drv_b", drv_b, want_b(m_st, m_s2));
        check(tag, "cyc_start", cyc_start, m_start);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int gap;
        bit c;
        void'($urandom(32'd7741));
        @(negedge clk);
        // R1: reset state
        rst = 1'b1;
        repeat (3) step(1, 0, 1, 8'd3, "R1");
        rst = 1'b0;
        repeat (4) step(0, 0, 1, 8'd3, "R2");

        // R3 R4: control 1, one-shot of 3, zc ends rest
        repeat (20) step(1, 0, 1, 8'd3, "R3 R4");
        step(1, 1, 1, 8'd3, "R6");
        repeat (10) step(1, 0, 1, 8'd3, "R3 R4");

        // R5: control 0
        repeat (40) step(1, 0, 0, 8'd4, "R5");

        // R6: zc inside one-shot ignored; wait for a start then pulse zc
        while (!cyc_start) step(1, 0, 0, 8'd5, "R6");
        step(1, 1, 0, 8'd5, "R6");
        step(1, 1, 0, 8'd5, "R6");
        check("R6", "still one-shot drv_b", drv_b, 2'b01);

        // R7: timeout at 8 x 2, period 18
        while (!cyc_start) step(1, 0, 1, 8'd2, "R7");
        gap = 0;
        do begin step(1, 0, 1, 8'd2, "R7"); gap++; end while (!cyc_start && gap < 100);
        check("R7", "period", gap, 18);

        // R9: length 0 behaves as 1, period 9
        while (!cyc_start) step(1, 0, 1, 8'd0, "R9");
        gap = 0;
        do begin step(1, 0, 1, 8'd0, "R9"); gap++; end while (!cyc_start && gap < 100);
        check("R9", "period", gap, 9);

        // R8: mid-rest flip shows after two edges, timing unchanged
        while (!cyc_start) step(1, 0, 1, 8'd6, "R8");
        repeat (8) step(1, 0, 1, 8'd6, "R8");
        step(1, 0, 0, 8'd6, "R8");
        check("R8", "drv_b one edge", drv_b, 2'b11);
        step(1, 0, 0, 8'd6, "R8");
        check("R8", "drv_a two edges", drv_a, 2'b11);
        gap = 10;
        do begin step(1, 0, 0, 8'd6, "R8"); gap++; end while (!cyc_start && gap < 200);
        check("R8", "period after flip", gap, 54);

        // R2: drop enable mid-cycle, then recover
        repeat (3) step(1, 0, 0, 8'd6, "R2");
        step(0, 0, 0, 8'd6, "R2");
        check("R2", "drv_a off", drv_a, 2'b00);
        step(1, 0, 0, 8'd6, "R2");
        check("R2", "restart strobe", cyc_start, 1);

        // random mix
        c = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            bit en, zc;
            logic [7:0] len;
            if ($urandom_range(0, 15) == 0) c = ~c;
            en  = ($urandom_range(0, 49) != 0);
            zc  = ($urandom_range(0, 5) == 0);
            len = 8'($urandom_range(0, 5));
            if (i % 200 != 0) len = shot_len;
            step(en, zc, c, len, "R2 R3 R4 R5 R6 R7 R8");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule